// File: doc/BRIEF.md
# I2C Bus Condition and Acknowledge Monitor

This block listens to the two wires of an I2C bus, clock and data, and reports what happens on them as single-cycle event pulses in the system clock domain. It works the same whether the local interface is a master or a slave, because it only observes the lines. Both lines first pass through a synchronizer. The block then recognises start and stop conditions and keeps a bus-busy flag that spans a transfer. Inside a transfer it counts bus clock pulses to find each acknowledge slot.

The acknowledge slot is judged on two different edges. A missing acknowledge (data high) is reported at the rising clock edge that opens the ninth bit. A present acknowledge (data low) is reported at the falling edge that closes it. An optional DMA request strobe goes with every detected acknowledge. A software-visible enable turns the monitor off: while it is low, the monitor is quiet and forgets the transfer it was tracking.

Top module: `i2c_bus_mon`

## Requirements
- R1: A start pulse (`start_o`) is produced when the synchronized data line falls while the synchronized clock line is high in both the current and the previous sample. The pulse appears after the third rising system-clock edge that samples the changed data input.
- R2: A stop pulse (`stop_o`) is produced when the synchronized data line rises while the clock line is high in both samples. It has the same latency as R1, and a start and a stop never pulse in the same cycle.
- R3: `busy_o` becomes 1 in the cycle a start pulse appears and becomes 0 in the cycle a stop pulse appears. It rises at no other time.
- R4: `nack_o` pulses for one cycle when data is high at the 9th rising bus-clock edge counted since the last start.
- R5: `ack_o` pulses for one cycle when data is low at the falling bus-clock edge that follows the 9th rising edge. `ack_o` and `nack_o` never pulse together.
- R6: `dma_req_o` pulses in the same cycle as `ack_o` when `dma_on_ack_i` is 1 at that edge. It is never high without `ack_o`.
- R7: The frame position counts rising bus-clock edges only while busy. It returns to zero on a start (including a repeated start mid-byte), on a stop, and on the falling edge that closes the 9th bit. The falling edge right after a start is therefore not counted.
- R8: While `en_i` is 0, no event pulse is produced, `busy_o` is 0, and the frame position is held at zero. Raising `en_i` again in the middle of a transfer yields no acknowledge events until a new start.
- R9: While `rst_ni` is low, all outputs are 0.
- R10: Bus clock pulses seen while the bus is not busy produce no acknowledge, no missing-acknowledge and no DMA events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable |
| dma_on_ack_i | input | 1 | Raise a DMA request with each detected acknowledge |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| busy_o | output | 1 | Bus busy flag |
| ack_o | output | 1 | Acknowledge detected pulse |
| nack_o | output | 1 | Acknowledge missing pulse |
| dma_req_o | output | 1 | DMA request strobe |

## Verification
The bench goes after a repeated start inserted after four bits. A counter that is not cleared there would put the acknowledge slot on the wrong pulse and report it early. It sends clock pulses while the bus is idle: a monitor that counted outside a transfer would report phantom acknowledges. It drops the enable halfway through a byte and raises it again: a design that kept its busy flag or bit position would report an acknowledge for a transfer it had abandoned. It also compares the two sampling edges of the ninth bit cycle by cycle, so that judging both outcomes on one edge, or letting the DMA strobe ignore its select, shows up as a pulse in the wrong cycle.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  // Two bus wires carried together
  typedef struct packed {
    logic scl;
    logic sda;
  } line_t;

  // Transition flags of one wire between two samples
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Start: data falls while the clock stays high across both samples
  function automatic logic start_seen(edge_t sda_e, logic scl_held_hi);
    return sda_e.fall & scl_held_hi;
  endfunction

  // Stop: data rises while the clock stays high across both samples
  function automatic logic stop_seen(edge_t sda_e, logic scl_held_hi);
    return sda_e.rise & scl_held_hi;
  endfunction

  // Next frame position: rising clock edges advance up to last,
  // the falling edge that closes the last bit returns to zero.
  function automatic int unsigned frame_next(int unsigned pos, edge_t scl_e,
                                             int unsigned last);
    int unsigned nxt;
    nxt = pos;
    if (scl_e.rise && pos < last) nxt = pos + 1;
    else if (scl_e.fall && pos == last) nxt = 0;
    return nxt;
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
      assign q_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_mon_edges.sv
module i2c_mon_edges
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t cur_i,
  output edge_t scl_e_o,
  output edge_t sda_e_o,
  output logic  scl_held_hi_o
);

  line_t prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= '{scl: 1'b1, sda: 1'b1};
    else         prv_q <= cur_i;
  end

  assign scl_e_o.rise  =  cur_i.scl & ~prv_q.scl;
  assign scl_e_o.fall  = ~cur_i.scl &  prv_q.scl;
  assign sda_e_o.rise  =  cur_i.sda & ~prv_q.sda;
  assign sda_e_o.fall  = ~cur_i.sda &  prv_q.sda;
  assign scl_held_hi_o =  cur_i.scl &  prv_q.scl;

endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  edge_t sda_e_i,
  input  logic  scl_held_hi_i,
  output logic  start_hit_o,
  output logic  stop_hit_o,
  output logic  busy_q_o,
  output logic  start_q_o,
  output logic  stop_q_o
);

  assign start_hit_o = en_i & start_seen(sda_e_i, scl_held_hi_i);
  assign stop_hit_o  = en_i & stop_seen(sda_e_i, scl_held_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q_o  <= 1'b0;
      start_q_o <= 1'b0;
      stop_q_o  <= 1'b0;
    end else begin
      start_q_o <= start_hit_o;
      stop_q_o  <= stop_hit_o;
      if (!en_i)            busy_q_o <= 1'b0;
      else if (start_hit_o) busy_q_o <= 1'b1;
      else if (stop_hit_o)  busy_q_o <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_mon_frame.sv
module i2c_mon_frame
  import i2c_mon_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          busy_i,
  input  logic          restart_i,
  input  edge_t         scl_e_i,
  input  logic          sda_i,
  input  logic          dma_on_ack_i,
  output logic [CW-1:0] pos_o,
  output logic          ack_hit_o,
  output logic          nack_hit_o,
  output logic          ack_q_o,
  output logic          nack_q_o,
  output logic          dma_q_o
);

  localparam logic [CW-1:0] LAST     = CW'(FRAME_BITS);
  localparam logic [CW-1:0] PRE_LAST = CW'(FRAME_BITS - 1);

  logic          tracking;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_nxt;

  assign tracking   = en_i & busy_i;
  assign nack_hit_o = tracking & scl_e_i.rise & (pos_q == PRE_LAST) & sda_i;
  assign ack_hit_o  = tracking & scl_e_i.fall & (pos_q == LAST) & ~sda_i;
  assign pos_nxt    = CW'(frame_next(int'(pos_q), scl_e_i, FRAME_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      ack_q_o  <= 1'b0;
      nack_q_o <= 1'b0;
      dma_q_o  <= 1'b0;
    end else begin
      ack_q_o  <= ack_hit_o;
      nack_q_o <= nack_hit_o;
      dma_q_o  <= ack_hit_o & dma_on_ack_i;
      if (!en_i || restart_i) pos_q <= '0;
      else if (busy_i)        pos_q <= pos_nxt;
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FRAME_BITS  = 9,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dma_on_ack_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o,
  output logic ack_o,
  output logic nack_o,
  output logic dma_req_o
);

  line_t         raw_line;
  line_t         sync_line;
  edge_t         scl_edge;
  edge_t         sda_edge;
  logic          scl_held_hi;
  logic          start_hit;
  logic          stop_hit;
  logic          ack_hit;
  logic          nack_hit;
  logic [CW-1:0] frame_pos;

  assign raw_line = '{scl: scl_i, sda: sda_i};

  i2c_mon_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_line),
    .q_o   (sync_line)
  );

  i2c_mon_edges u_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cur_i        (sync_line),
    .scl_e_o      (scl_edge),
    .sda_e_o      (sda_edge),
    .scl_held_hi_o(scl_held_hi)
  );

  i2c_mon_cond u_cond (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .sda_e_i      (sda_edge),
    .scl_held_hi_i(scl_held_hi),
    .start_hit_o  (start_hit),
    .stop_hit_o   (stop_hit),
    .busy_q_o     (busy_o),
    .start_q_o    (start_o),
    .stop_q_o     (stop_o)
  );

  i2c_mon_frame #(
    .FRAME_BITS(FRAME_BITS)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .busy_i      (busy_o),
    .restart_i   (start_hit | stop_hit),
    .scl_e_i     (scl_edge),
    .sda_i       (sync_line.sda),
    .dma_on_ack_i(dma_on_ack_i),
    .pos_o       (frame_pos),
    .ack_hit_o   (ack_hit),
    .nack_hit_o  (nack_hit),
    .ack_q_o     (ack_o),
    .nack_q_o    (nack_o),
    .dma_q_o     (dma_req_o)
  );

endmodule

// File: rtl/i2c_bus_mon_chk.sv
module i2c_bus_mon_chk #(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          start_o,
  input logic          stop_o,
  input logic          busy_o,
  input logic          ack_o,
  input logic          nack_o,
  input logic          dma_req_o,
  input logic [CW-1:0] frame_pos
);

  // R2
  start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));

  // R3
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  // R3
  stop_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o);

  // R3
  busy_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);

  // R5
  ack_nack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && nack_o));

  // R5
  ack_closes_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (frame_pos == '0 && $past(frame_pos) == CW'(FRAME_BITS)));

  // R4
  nack_reaches_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> frame_pos == CW'(FRAME_BITS));

  // R6
  dma_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> ack_o);

  // R7
  pos_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pos <= CW'(FRAME_BITS));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(start_o || stop_o || ack_o || nack_o || dma_req_o || busy_o));

  // R10
  ack_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || nack_o) |-> busy_o);

endmodule

bind i2c_bus_mon i2c_bus_mon_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .start_o  (start_o),
  .stop_o   (stop_o),
  .busy_o   (busy_o),
  .ack_o    (ack_o),
  .nack_o   (nack_o),
  .dma_req_o(dma_req_o),
  .frame_pos(frame_pos)
);

// File: tb/i2c_bus_mon_tb_top.sv
module i2c_bus_mon_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int DEPTH      = 4;   // two sync stages plus current and previous

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic dma_on = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic start_w, stop_w, busy_w, ack_w, nack_w, dma_w;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int seen_start = 0, seen_stop = 0, seen_ack = 0, seen_nack = 0, seen_dma = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bus_mon dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .dma_on_ack_i(dma_on),
    .scl_i       (scl),
    .sda_i       (sda),
    .start_o     (start_w),
    .stop_o      (stop_w),
    .busy_o      (busy_w),
    .ack_o       (ack_w),
    .nack_o      (nack_w),
    .dma_req_o   (dma_w)
  );

  task automatic check(string tag, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0] hist[$];          // {scl,sda}, newest first
  bit m_busy;
  int m_pos;
  bit e_start, e_stop, e_ack, e_nack, e_dma;
  // inputs that the next rising edge samples
  bit p_rst = 1'b0, p_en = 1'b1, p_dma = 1'b0, p_scl = 1'b1, p_sda = 1'b1;

  initial begin
    for (int i = 0; i < DEPTH; i++) hist.push_front(2'b11);
  end

  always @(negedge clk) begin
    if (!p_rst) begin
      hist.delete();
      for (int i = 0; i < DEPTH; i++) hist.push_front(2'b11);
      m_busy = 0; m_pos = 0;
      {e_start, e_stop, e_ack, e_nack, e_dma} = '0;
    end else begin
      logic [1:0] now_s, old_s;
      bit sclhi, scl_up, scl_dn, sda_up, sda_dn;
      hist.push_front({p_scl, p_sda});
      void'(hist.pop_back());
      now_s = hist[2];
      old_s = hist[3];
      sclhi  = now_s[1] && old_s[1];
      scl_up = now_s[1] && !old_s[1];
      scl_dn = !now_s[1] && old_s[1];
      sda_up = now_s[0] && !old_s[0];
      sda_dn = !now_s[0] && old_s[0];
      e_start = p_en && sda_dn && sclhi;
      e_stop  = p_en && sda_up && sclhi;
      e_nack  = p_en && m_busy && scl_up && m_pos == 8 && now_s[0];
      e_ack   = p_en && m_busy && scl_dn && m_pos == 9 && !now_s[0];
      e_dma   = e_ack && p_dma;
      if (!p_en || e_start || e_stop) m_pos = 0;
      else if (m_busy) begin
        if (scl_up && m_pos < 9) m_pos++;
        else if (scl_dn && m_pos == 9) m_pos = 0;
      end
      if (!p_en) m_busy = 0;
      else if (e_start) m_busy = 1;
      else if (e_stop) m_busy = 0;
    end
    check("R1 start_o", int'(start_w), int'(e_start));
    check("R2 stop_o", int'(stop_w), int'(e_stop));
    check("R3 busy_o", int'(busy_w), int'(m_busy));
    check("R4 nack_o", int'(nack_w), int'(e_nack));
    check("R5 ack_o", int'(ack_w), int'(e_ack));
    check("R6 dma_req_o", int'(dma_w), int'(e_dma));
    seen_start += int'(start_w); seen_stop += int'(stop_w);
    seen_ack += int'(ack_w); seen_nack += int'(nack_w); seen_dma += int'(dma_w);
    p_rst = rst_n; p_en = en; p_dma = dma_on; p_scl = scl; p_sda = sda;
  end

  // ---------------- bus drivers ----------------
  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda = 1'b1; cyc(HOLD);
    scl = 1'b1; cyc(HOLD);
    sda = 1'b0; cyc(HOLD);
    scl = 1'b0; cyc(HOLD);
  endtask

  task automatic bus_stop();
    sda = 1'b0; cyc(HOLD);
    scl = 1'b1; cyc(HOLD);
    sda = 1'b1; cyc(HOLD);
  endtask

  task automatic bus_bit(bit b);
    sda = b;    cyc(HOLD);
    scl = 1'b1; cyc(HOLD);
    scl = 1'b0; cyc(HOLD);
  endtask

  task automatic bus_byte(logic [7:0] d, bit ack_bit);
    for (int i = 7; i >= 0; i--) bus_bit(d[i]);
    bus_bit(ack_bit);
  endtask

  int s0, s1, s2, s3, s4;
  task automatic snap();
    s0 = seen_start; s1 = seen_stop; s2 = seen_ack; s3 = seen_nack; s4 = seen_dma;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    cyc(5);
    // R9: outputs quiet in reset
    check("R9 reset outputs", int'({start_w, stop_w, busy_w, ack_w, nack_w, dma_w}), 0);
    rst_n = 1'b1;
    cyc(6);
    check("R9 idle after reset", int'({start_w, stop_w, busy_w, ack_w, nack_w, dma_w}), 0);

    // acknowledged byte, DMA not selected
    snap();
    bus_start(); cyc(2);
    check("R1 one start", seen_start - s0, 1);
    check("R3 busy after start", int'(busy_w), 1);
    bus_byte(8'hA5, 1'b0); cyc(2);
    check("R5 one ack", seen_ack - s2, 1);
    check("R6 no dma when off", seen_dma - s4, 0);

    // acknowledged byte, DMA selected
    dma_on = 1'b1; snap();
    bus_byte(8'h3C, 1'b0); cyc(2);
    check("R6 dma with ack", seen_dma - s4, 1);
    check("R5 ack second byte", seen_ack - s2, 1);

    // missing acknowledge
    snap();
    bus_byte(8'hFF, 1'b1); cyc(2);
    check("R4 one nack", seen_nack - s3, 1);
    check("R5 no ack on nack", seen_ack - s2, 0);
    check("R6 no dma on nack", seen_dma - s4, 0);

    // repeated start after four bits, then a full byte
    snap();
    for (int i = 0; i < 4; i++) bus_bit(1'b0);
    bus_start();
    bus_byte(8'h00, 1'b0); cyc(2);
    check("R7 repeated start seen", seen_start - s0, 1);
    check("R7 single ack after restart", seen_ack - s2, 1);
    check("R7 no nack after restart", seen_nack - s3, 0);

    // stop
    snap();
    bus_stop(); cyc(2);
    check("R2 one stop", seen_stop - s1, 1);
    check("R3 busy cleared", int'(busy_w), 0);

    // clock pulses while idle
    snap();
    scl = 1'b0; cyc(HOLD);
    for (int i = 0; i < 9; i++) bus_bit(1'b0);
    for (int i = 0; i < 9; i++) bus_bit(1'b1);
    sda = 1'b1; cyc(HOLD); scl = 1'b1; cyc(HOLD);
    check("R10 no ack idle", seen_ack - s2, 0);
    check("R10 no nack idle", seen_nack - s3, 0);
    check("R10 no dma idle", seen_dma - s4, 0);

    // disabled monitor sees a whole transfer
    en = 1'b0; snap();
    bus_start(); bus_byte(8'h5A, 1'b0); bus_stop(); cyc(2);
    check("R8 no start off", seen_start - s0, 0);
    check("R8 no ack off", seen_ack - s2, 0);
    check("R8 no stop off", seen_stop - s1, 0);
    en = 1'b1; cyc(4);

    // enable dropped mid-byte
    snap();
    bus_start();
    for (int i = 0; i < 3; i++) bus_bit(1'b1);
    en = 1'b0; cyc(3);
    check("R8 busy drops", int'(busy_w), 0);
    en = 1'b1;
    for (int i = 0; i < 5; i++) bus_bit(1'b0);
    bus_bit(1'b0);
    cyc(2);
    check("R8 no ack after reenable", seen_ack - s2, 0);
    check("R8 busy stays low", int'(busy_w), 0);
    bus_stop(); cyc(2);
    check("R2 stop while idle", seen_stop - s1, 1);

    // a final clean transfer
    snap();
    bus_start(); bus_byte(8'h81, 1'b0); bus_stop(); cyc(4);
    check("R5 final ack", seen_ack - s2, 1);
    check("R3 final idle", int'(busy_w), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule